// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of general-purpose pins reached through a simple word-wide register bus. Every pin owns a small register group: a configuration word that holds its output enable, an input/output word that shows the synchronized pad level and holds the value to drive, an interrupt configuration word, a status word and a routing word. Software sets a pin's direction and output value, reads its input, and arms a detector that fires on one edge or on one level with a selectable polarity.

When the detector fires, two independent switches decide what happens next. The raw-status switch lets the trigger latch into the pin's status bit. The interrupt switch lets the pin raise its interrupt: from the latched status when latching is on, or straight from the trigger when it is off. A per-pin routing code decides whether that interrupt reaches the single summary interrupt output. Status stays latched until software writes a one to the status word.

Each pin's status holder is a two-state machine. State `ST_CLEAR` moves to `ST_PENDING` on transition CATCH (raw-status enabled, trigger present, no acknowledge this cycle). `ST_PENDING` returns to `ST_CLEAR` on transition ACK (a write of one to status bit 0). Both states stay put otherwise (transition HOLD). The acknowledge wins over a trigger in the same cycle.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin's configuration, output value, interrupt configuration and status read 0, every routing code reads 7, `pin_oe` and `pin_out` are 0 and `irq_summary` is 0.
- R2: Bit 9 of the configuration word (byte address 0x1000 + 0x10·n) drives `pin_oe[n]`, and bit 1 of the input/output word (0x1004 + 0x10·n) drives `pin_out[n]`. Both read back at the same positions.
- R3: Bit 0 of the input/output word reads the pad level through a two-flop synchronizer. A read whose request is sampled one or two clock edges after the pad changes still returns the old level, and from the third edge the new one.
- R4: Interrupt configuration (0x1008 + 0x10·n) bit 2 = 1 selects edge detection. Bit 1 = 1 then catches only rising edges and bit 1 = 0 only falling edges. The opposite edge and a steady level never latch status (0x100C + 0x10·n, bit 0).
- R5: With bit 2 = 0 (level detection), status latches while the pad is high (bit 1 = 1) or low (bit 1 = 0). A latched status stays set after the level goes away. After an acknowledge the status reads 0 in the next cycle and sets again one cycle later if the active level persists.
- R6: Status latches only when raw-status enable (interrupt configuration bit 3) is 1. With bit 3 = 0 and interrupt enable (bit 0) = 1, a detected edge still pulses `irq_summary` for exactly one cycle, three clock edges after the pad change, while status stays 0.
- R7: Writing 1 to status bit 0 clears that pin's status. Writing 0 leaves it unchanged.
- R8: `irq_summary` is the registered OR over pins of (interrupt enable AND routing code (0x0400 + 0x04·n, bits 2:0) = 4 AND pin interrupt). It rises one cycle after status latches. It drops one cycle after the routing code becomes 7 or the interrupt enable is cleared.
- R9: Reads of addresses that map to no implemented pin or register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 13 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Output values toward the pads |
| pin_oe | output | NPINS | Output enables toward the pads |
| irq_summary | output | 1 | Summary interrupt toward the processor |

## Verification
The assertions assume the bus issues at most one access per cycle and that output enables change only as the result of a bus write. They also assume the pad inputs need no timing relation to the clock beyond what the synchronizer absorbs. The bench drives every bus strobe and pad change on the falling clock edge, keeps read and write strobes apart, and holds each pad steady for several cycles between changes. It sweeps every pin through all four detector modes with both transitions, and computes each expected status from the mode, the polarity and the pad history.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ADDR_W      = 13;
    localparam int DATA_W      = 32;
    localparam int SYNC_STAGES = 2;
    localparam int IDX_W       = 8;

    localparam int OE_BIT  = 9;
    localparam int OUT_BIT = 1;
    localparam int IN_BIT  = 0;

    localparam int IC_IEN  = 0;
    localparam int IC_POL  = 1;
    localparam int IC_EDGE = 2;
    localparam int IC_RAW  = 3;
    localparam int IC_W    = 4;

    localparam int ROUTE_W = 3;
    localparam logic [ROUTE_W-1:0] ROUTE_PROC = 3'd4;
    localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_IO   = 2'd1,
        SEL_ICFG = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_PENDING = 1'b1
    } stat_state_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_in,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wr_cfg,
    input  logic               wr_io,
    input  logic               wr_icfg,
    input  logic               wr_stat,
    input  logic               wr_route,
    output logic               oe,
    output logic               out_val,
    output logic               in_sync,
    output logic [IC_W-1:0]    icfg,
    output logic [ROUTE_W-1:0] route,
    output logic               stat,
    output logic               stat_clr,
    output logic               irq
);
    logic        prev_q;
    logic        rise, fall, trig, catch_now;
    stat_state_e state_q, state_d;
    logic        unused_wdata;

    assign unused_wdata = ^{wdata[DATA_W-1:OE_BIT+1], wdata[OE_BIT-1:IC_W]};

    gpio_bank_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_sync)
    );

    // software-visible per-pin registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe      <= 1'b0;
            out_val <= 1'b0;
            icfg    <= '0;
            route   <= ROUTE_NONE;
        end else begin
            if (wr_cfg)   oe      <= wdata[OE_BIT];
            if (wr_io)    out_val <= wdata[OUT_BIT];
            if (wr_icfg)  icfg    <= wdata[IC_W-1:0];
            if (wr_route) route   <= wdata[ROUTE_W-1:0];
        end
    end

    // previous synchronized level for edge comparison
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= in_sync;
    end

    assign rise = in_sync & ~prev_q;
    assign fall = ~in_sync & prev_q;

    always_comb begin
        if (icfg[IC_EDGE]) trig = icfg[IC_POL] ? rise : fall;
        else               trig = icfg[IC_POL] ? in_sync : ~in_sync;
    end

    assign stat_clr  = wr_stat & wdata[0];
    assign catch_now = icfg[IC_RAW] & trig & ~stat_clr;

    // status state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // next state: CATCH, ACK, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:   if (catch_now) state_d = ST_PENDING;
            ST_PENDING: if (stat_clr)  state_d = ST_CLEAR;
            default:    state_d = ST_CLEAR;
        endcase
    end

    // outputs of the status machine
    always_comb begin
        stat = (state_q == ST_PENDING);
        irq  = icfg[IC_IEN] & (stat | (trig & ~icfg[IC_RAW]));
    end
endmodule

// File: rtl/gpio_bank_regif.sv
module gpio_bank_regif
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [NPINS-1:0]                oe_vec,
    input  logic [NPINS-1:0]                out_vec,
    input  logic [NPINS-1:0]                in_vec,
    input  logic [NPINS-1:0][IC_W-1:0]      icfg_vec,
    input  logic [NPINS-1:0]                stat_vec,
    input  logic [NPINS-1:0][ROUTE_W-1:0]   route_vec,
    output logic [NPINS-1:0]                wr_cfg,
    output logic [NPINS-1:0]                wr_io,
    output logic [NPINS-1:0]                wr_icfg,
    output logic [NPINS-1:0]                wr_stat,
    output logic [NPINS-1:0]                wr_route,
    output logic [DATA_W-1:0]               rdata
);
    logic             pin_area, rt_area;
    logic [IDX_W-1:0] pin_idx, rt_idx;
    reg_sel_e         sel;
    logic [DATA_W-1:0] rd_next;
    logic             unused_addr;

    assign unused_addr = ^addr[1:0];
    assign pin_area    = addr[12];
    assign rt_area     = (addr[12:10] == 3'b001);
    assign pin_idx     = addr[11:4];
    assign rt_idx      = addr[9:2];
    assign sel         = reg_sel_e'(addr[3:2]);

    for (genvar i = 0; i < NPINS; i++) begin : g_dec
        logic hit_pin, hit_rt;
        assign hit_pin     = wr_en & pin_area & (pin_idx == IDX_W'(i));
        assign hit_rt      = wr_en & rt_area  & (rt_idx  == IDX_W'(i));
        assign wr_cfg[i]   = hit_pin & (sel == SEL_CFG);
        assign wr_io[i]    = hit_pin & (sel == SEL_IO);
        assign wr_icfg[i]  = hit_pin & (sel == SEL_ICFG);
        assign wr_stat[i]  = hit_pin & (sel == SEL_STAT);
        assign wr_route[i] = hit_rt;
    end

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (pin_area && pin_idx == IDX_W'(i)) begin
                unique case (sel)
                    SEL_CFG:  rd_next[OE_BIT] = oe_vec[i];
                    SEL_IO:   begin
                        rd_next[IN_BIT]  = in_vec[i];
                        rd_next[OUT_BIT] = out_vec[i];
                    end
                    SEL_ICFG: rd_next[IC_W-1:0] = icfg_vec[i];
                    SEL_STAT: rd_next[0] = stat_vec[i];
                    default:  rd_next = '0;
                endcase
            end
            if (rt_area && rt_idx == IDX_W'(i))
                rd_next[ROUTE_W-1:0] = route_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_summary
);
    logic [NPINS-1:0]              wr_cfg, wr_io, wr_icfg, wr_stat, wr_route;
    logic [NPINS-1:0]              in_vec, stat_vec, clr_vec, irq_vec;
    logic [NPINS-1:0]              raw_vec, routed_en, to_proc;
    logic [NPINS-1:0][IC_W-1:0]    icfg_vec;
    logic [NPINS-1:0][ROUTE_W-1:0] route_vec;

    gpio_bank_regif #(.NPINS(NPINS)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .oe_vec    (pin_oe),
        .out_vec   (pin_out),
        .in_vec    (in_vec),
        .icfg_vec  (icfg_vec),
        .stat_vec  (stat_vec),
        .route_vec (route_vec),
        .wr_cfg    (wr_cfg),
        .wr_io     (wr_io),
        .wr_icfg   (wr_icfg),
        .wr_stat   (wr_stat),
        .wr_route  (wr_route),
        .rdata     (bus_rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_bank_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_in   (pin_in[i]),
            .wdata    (bus_wdata),
            .wr_cfg   (wr_cfg[i]),
            .wr_io    (wr_io[i]),
            .wr_icfg  (wr_icfg[i]),
            .wr_stat  (wr_stat[i]),
            .wr_route (wr_route[i]),
            .oe       (pin_oe[i]),
            .out_val  (pin_out[i]),
            .in_sync  (in_vec[i]),
            .icfg     (icfg_vec[i]),
            .route    (route_vec[i]),
            .stat     (stat_vec[i]),
            .stat_clr (clr_vec[i]),
            .irq      (irq_vec[i])
        );
        assign raw_vec[i]   = icfg_vec[i][IC_RAW];
        assign to_proc[i]   = (route_vec[i] == ROUTE_PROC);
        assign routed_en[i] = icfg_vec[i][IC_IEN] & to_proc[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_summary <= 1'b0;
        else        irq_summary <= |(irq_vec & to_proc);
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq_summary,
    input logic [NPINS-1:0] routed_en,
    input logic [NPINS-1:0] stat_vec,
    input logic [NPINS-1:0] raw_vec,
    input logic [NPINS-1:0] clr_vec
);
    // R1: nothing is driven or signalled in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_summary && pin_oe == '0));

    // R2: output enables only move after a bus write
    a_r2_oe_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(bus_wr));

    // R6: a status bit never rises unless raw latching was enabled
    a_r6_latch_gated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((stat_vec & ~$past(stat_vec) & ~$past(raw_vec)) == '0));

    // R7: an acknowledge leaves the status clear in the following cycle
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((stat_vec & $past(clr_vec)) == '0));

    // R8: the summary only rises for an enabled pin routed to the processor
    a_r8_summary_routed: assert property (@(posedge clk) disable iff (!rst_n)
        irq_summary |-> ($past(routed_en) != '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .pin_oe      (pin_oe),
    .irq_summary (irq_summary),
    .routed_en   (routed_en),
    .stat_vec    (stat_vec),
    .raw_vec     (raw_vec),
    .clr_vec     (clr_vec)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int NPINS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_out, pin_oe;
    logic        irq_summary;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_bank #(.NPINS(NPINS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_summary(irq_summary)
    );

    function automatic logic [12:0] a_cfg(int p);   return 13'(32'h1000 + 16*p); endfunction
    function automatic logic [12:0] a_io(int p);    return 13'(32'h1004 + 16*p); endfunction
    function automatic logic [12:0] a_icfg(int p);  return 13'(32'h1008 + 16*p); endfunction
    function automatic logic [12:0] a_stat(int p);  return 13'(32'h100C + 16*p); endfunction
    function automatic logic [12:0] a_route(int p); return 13'(32'h0400 + 4*p);  endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // called on a falling edge, returns on a falling edge
    task automatic wr(logic [12:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [12:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq_summary}, 0);
        check("R1 oe", {24'b0, pin_oe}, 0);
        check("R1 out", {24'b0, pin_out}, 0);
        for (int p = 0; p < NPINS; p++) begin
            rd(a_cfg(p), d);   check("R1 cfg", d, 0);
            rd(a_icfg(p), d);  check("R1 icfg", d, 0);
            rd(a_stat(p), d);  check("R1 stat", d, 0);
            rd(a_route(p), d); check("R1 route", d, 7);
        end

        // R2 direction and output value
        wr(a_cfg(2), 32'h200);
        check("R2 oe", {24'b0, pin_oe}, 32'h04);
        wr(a_io(2), 32'h2);
        check("R2 out", {24'b0, pin_out}, 32'h04);
        rd(a_cfg(2), d); check("R2 cfg readback", d, 32'h200);
        rd(a_io(2), d);  check("R2 io readback", d, 32'h2);
        wr(a_cfg(2), 0); wr(a_io(2), 0);
        check("R2 oe off", {24'b0, pin_oe}, 0);

        // R3 synchronizer latency
        pin_in[1] = 1'b1;
        rd(a_io(1), d); check("R3 first edge", d, 0);
        rd(a_io(1), d); check("R3 second edge", d, 0);
        rd(a_io(1), d); check("R3 third edge", d, 1);
        pin_in[1] = 1'b0;
        idle(5);

        // R4 / R5 sweep of every pin over all detector modes
        for (int p = 0; p < NPINS; p++) begin
            for (int m = 0; m < 4; m++) begin
                int edge_m, pol, s1, t1, s2, t2;
                edge_m = m >> 1; pol = m & 1;
                pin_in[p] = 1'b0;
                idle(5);
                wr(a_icfg(p), 32'(8 | (edge_m << 2) | (pol << 1)));
                wr(a_stat(p), 1);
                idle(3);
                s1 = (edge_m == 0 && pol == 0) ? 1 : 0;
                rd(a_stat(p), d); check(edge_m ? "R4 steady low" : "R5 steady low", d, 32'(s1));
                pin_in[p] = 1'b1;
                idle(5);
                t1 = s1 | ((pol == 1) ? 1 : 0);
                rd(a_stat(p), d); check(edge_m ? "R4 after rise" : "R5 after rise", d, 32'(t1));
                wr(a_stat(p), 1);
                idle(3);
                s2 = (edge_m == 0 && pol == 1) ? 1 : 0;
                rd(a_stat(p), d); check(edge_m ? "R4 steady high" : "R5 steady high", d, 32'(s2));
                pin_in[p] = 1'b0;
                idle(5);
                t2 = s2 | ((pol == 0) ? 1 : 0);
                rd(a_stat(p), d); check(edge_m ? "R4 after fall" : "R5 after fall", d, 32'(t2));
                wr(a_icfg(p), 0);
                wr(a_stat(p), 1);
            end
        end

        // R5 re-latch one cycle after acknowledge with level still active
        wr(a_icfg(5), 32'hA);
        pin_in[5] = 1'b1;
        idle(5);
        wr(a_stat(5), 1);
        rd(a_stat(5), d); check("R5 cleared next cycle", d, 0);
        rd(a_stat(5), d); check("R5 re-latched", d, 1);
        wr(a_icfg(5), 0); wr(a_stat(5), 1);
        pin_in[5] = 1'b0;
        idle(5);

        // R7 writing zero to status keeps it
        wr(a_icfg(6), 32'hE);
        pin_in[6] = 1'b1;
        idle(5);
        wr(a_stat(6), 0);
        rd(a_stat(6), d); check("R7 write zero kept", d, 1);
        wr(a_stat(6), 1);
        rd(a_stat(6), d); check("R7 write one cleared", d, 0);
        wr(a_icfg(6), 0);
        pin_in[6] = 1'b0;
        idle(5);

        // R6 interrupt without latching: one-cycle pulse, status stays 0
        wr(a_icfg(4), 32'h7);
        wr(a_route(4), 4);
        idle(2);
        pin_in[4] = 1'b1;
        idle(2);
        check("R6 before pulse", {31'b0, irq_summary}, 0);
        idle(1);
        check("R6 pulse high", {31'b0, irq_summary}, 1);
        idle(1);
        check("R6 pulse ended", {31'b0, irq_summary}, 0);
        rd(a_stat(4), d); check("R6 status untouched", d, 0);
        wr(a_icfg(4), 0); wr(a_route(4), 7);
        pin_in[4] = 1'b0;
        idle(5);

        // R8 latched summary, routing and enable gating
        wr(a_icfg(3), 32'hF);
        wr(a_route(3), 4);
        idle(2);
        pin_in[3] = 1'b1;
        idle(3);
        check("R8 one cycle after status", {31'b0, irq_summary}, 0);
        idle(1);
        check("R8 summary high", {31'b0, irq_summary}, 1);
        wr(a_route(3), 7);
        check("R8 route change not yet", {31'b0, irq_summary}, 1);
        idle(1);
        check("R8 route 7 blocks", {31'b0, irq_summary}, 0);
        wr(a_route(3), 4);
        idle(1);
        check("R8 route 4 again", {31'b0, irq_summary}, 1);
        wr(a_icfg(3), 32'hE);
        idle(1);
        check("R8 enable off blocks", {31'b0, irq_summary}, 0);
        rd(a_stat(3), d); check("R8 status still latched", d, 1);
        wr(a_icfg(3), 0); wr(a_stat(3), 1); wr(a_route(3), 7);
        pin_in[3] = 1'b0;
        idle(5);

        // R9 unmapped addresses
        rd(a_cfg(NPINS), d);   check("R9 pin beyond bank", d, 0);
        rd(a_route(NPINS), d); check("R9 route beyond bank", d, 0);
        rd(13'h0000, d);       check("R9 low hole", d, 0);
        rd(13'h0800, d);       check("R9 mid hole", d, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule